// File: doc/BRIEF.md
# Dual Stack RAM With Limit Check

This block keeps two stacks in one 64-word by 16-bit memory. A subroutine stack uses a single pointer and grows upward. A register stack grows downward and has two pointers, a local one and a global one. A select input decides which of the two is active. The block carries out pushes and pops on both stacks. It can also read a register at a small offset from the active register-stack pointer, and it can add an immediate value to that pointer to discard entries. Each pointer can be preloaded directly.

A 4-bit limit value marks a boundary at a multiple of four words. When a push writes to the boundary word, the block raises a one-cycle overflow pulse. Subroutine pushes use the boundary word with low bits 00, and register pushes use the one with low bits 11. Because the boundary sits three words short of the next block of four, three further pushes can still complete before the other stack's area is reached. Popping memory address zero raises a one-cycle underflow pulse, which supports stack paging. All results are registered and appear one cycle after the command.

Top module: `dual_stack_ram`

## Requirements
- R1: After reset, all three pointers read 0, and `rd_valid_o`, `ovf_o` and `udf_o` are low.
- R2: A subroutine push first increments the subroutine pointer and then writes `wr_data_i` at the new value. A subroutine pop reads the word at the current pointer and then decrements the pointer. The popped word appears on `rd_data_o` with `rd_valid_o` high one cycle after the command.
- R3: A register push first decrements the active register pointer and then writes at the new value. A register pop reads at the active pointer and then increments it. Data returns one cycle later.
- R4: `sel_glb_i` = 0 makes the local pointer active and 1 makes the global pointer active. A register-stack command never changes the pointer that is not active.
- R5: A register read with `reg_idx_i` = k (0 to 3) returns the word at the active pointer plus k, modulo 64, one cycle later. It leaves all pointers unchanged.
- R6: An adjust adds `adj_val_i` to the active register pointer, modulo 64.
- R7: Each load input sets its pointer to `ld_val_i` in the next cycle. While any load input is high, all stack commands in that cycle are ignored: no write, no read and no pointer step.
- R8: `ovf_o` is high for exactly the cycle after a push whose write address equals {`limit_i`, 2'b00} for a subroutine push, or {`limit_i`, 2'b11} for a register push. It is low after every other cycle.
- R9: `udf_o` is high for exactly the cycle after a pop, on either stack, that reads address 0.
- R10: Only one stack command runs per cycle. The order of priority is: subroutine pop, register pop, register read, subroutine push, register push, adjust. A push that arrives together with any pop is dropped: its pointer does not change and nothing is written.
- R11: Pointers wrap modulo 64. A subroutine push at 63 writes address 0, and a register push at 0 writes address 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_push_i | input | 1 | Push `wr_data_i` onto the subroutine stack |
| sub_pop_i | input | 1 | Pop the subroutine stack |
| reg_push_i | input | 1 | Push `wr_data_i` onto the register stack |
| reg_pop_i | input | 1 | Pop the register stack |
| reg_rd_i | input | 1 | Read the register at active pointer + `reg_idx_i` |
| reg_idx_i | input | 2 | Register offset 0 to 3 |
| adj_i | input | 1 | Add `adj_val_i` to the active register pointer |
| adj_val_i | input | 6 | Adjust amount, modulo 64 |
| sel_glb_i | input | 1 | 0: local pointer active, 1: global pointer active |
| ld_sub_i | input | 1 | Load the subroutine pointer |
| ld_loc_i | input | 1 | Load the local pointer |
| ld_glb_i | input | 1 | Load the global pointer |
| ld_val_i | input | 6 | Value for the pointer loads |
| limit_i | input | 4 | Stack limit, in units of four words |
| wr_data_i | input | 16 | Data to push |
| rd_data_o | output | 16 | Data from a pop or a register read |
| rd_valid_o | output | 1 | `rd_data_o` holds new data this cycle |
| ovf_o | output | 1 | Overflow pulse |
| udf_o | output | 1 | Underflow pulse |
| sub_ptr_o | output | 6 | Subroutine pointer |
| loc_ptr_o | output | 6 | Local register pointer |
| glb_ptr_o | output | 6 | Global register pointer |

## Verification
Every result of a command is due exactly one cycle after the rising edge that samples the command. This holds for the read data and its valid bit, both flag pulses and the new pointer values, because each of them sits behind one register. The bench drives each command just after a falling edge and holds it through one rising edge. It then compares all outputs at the next falling edge, so every check falls in the cycle where that result is due. In the following cycle the bench can see whether a pulse has dropped again. Dropped or ignored commands are checked through the pointer outputs and by reading back the word they would have overwritten.

// File: rtl/dstk_pkg.sv
package dstk_pkg;

   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_SPOP  = 3'd1,
      OP_RPOP  = 3'd2,
      OP_RRD   = 3'd3,
      OP_SPUSH = 3'd4,
      OP_RPUSH = 3'd5,
      OP_ADJ   = 3'd6
   } stk_op_e;

   localparam int unsigned N_PTR = 3;
   localparam logic [1:0] IX_SUB = 2'd0;
   localparam logic [1:0] IX_LOC = 2'd1;
   localparam logic [1:0] IX_GLB = 2'd2;

endpackage

// File: rtl/dstk_ptr.sv
module dstk_ptr #(
   parameter int unsigned    AW      = 6,
   parameter logic [AW-1:0]  RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_i,
   input  logic [AW-1:0] ld_val_i,
   input  logic          step_i,
   input  logic [AW-1:0] delta_i,
   output logic [AW-1:0] q_o
);

   if (AW < 2) begin : g_bad_aw
      $error("dstk_ptr: AW must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q_o <= RST_VAL;
      else if (ld_i)
         q_o <= ld_val_i;
      else if (step_i)
         q_o <= q_o + delta_i;
   end

   // R7: a load lands in the next cycle
   a_r7_load_value : assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> (q_o == $past(ld_val_i)));

   // R11: an idle pointer keeps its value
   a_r11_idle_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_i && !step_i) |=> $stable(q_o));

endmodule

// File: rtl/dstk_mem.sv
module dstk_mem #(
   parameter int unsigned DW          = 16,
   parameter int unsigned AW          = 6,
   parameter bit          CLR_IDLE_RD = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          re_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o,
   output logic          rvalid_o
);

   localparam int unsigned DEPTH = 1 << AW;

   if (DEPTH > 4096) begin : g_bad_depth
      $error("dstk_mem: depth above 4096 words");
   end
   if (DW == 0) begin : g_bad_dw
      $error("dstk_mem: DW must be positive");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (we_i)
         mem[waddr_i] <= wdata_i;
   end

   always_ff @(posedge clk) begin
      if (re_i)
         rd_q <= mem[raddr_i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rvalid_o <= 1'b0;
      else
         rvalid_o <= re_i;
   end

   if (CLR_IDLE_RD) begin : g_rd_clear
      assign rdata_o = rvalid_o ? rd_q : '0;
   end else begin : g_rd_hold
      assign rdata_o = rd_q;
   end

   // R10: one command per cycle, so a read and a write never coincide
   a_r10_no_rw_overlap : assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && re_i));

   // R2: read data is flagged valid exactly one cycle after a read
   a_r2_valid_follows_read : assert property (@(posedge clk) disable iff (!rst_n)
      re_i |=> rvalid_o);

endmodule

// File: rtl/dstk_flags.sv
module dstk_flags #(
   parameter int unsigned AW = 6,
   parameter int unsigned LW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          push_reg_i,
   input  logic [AW-1:0] wr_addr_i,
   input  logic          pop_i,
   input  logic [AW-1:0] rd_addr_i,
   input  logic [LW-1:0] limit_i,
   output logic          ovf_o,
   output logic          udf_o
);

   localparam int unsigned FW = AW - LW;

   if (LW == 0 || LW >= AW) begin : g_bad_lw
      $error("dstk_flags: LW must be between 1 and AW-1");
   end

   localparam logic [FW-1:0] FILL_SUB = '0;
   localparam logic [FW-1:0] FILL_REG = '1;

   logic [AW-1:0] lim_addr;
   logic          hit;

   assign lim_addr = {limit_i, (push_reg_i ? FILL_REG : FILL_SUB)};
   assign hit      = push_i && (wr_addr_i == lim_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_o <= 1'b0;
         udf_o <= 1'b0;
      end else begin
         ovf_o <= hit;
         udf_o <= pop_i && (rd_addr_i == '0);
      end
   end

   // R8: no overflow pulse without a push in the cycle before
   a_r8_ovf_needs_push : assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> $past(push_i));

   // R9: an underflow pulse follows only a pop of address zero
   a_r9_udf_zero_pop : assert property (@(posedge clk) disable iff (!rst_n)
      udf_o |-> ($past(pop_i) && ($past(rd_addr_i) == '0)));

endmodule

// File: rtl/dual_stack_ram.sv
module dual_stack_ram
   import dstk_pkg::*;
#(
   parameter int unsigned DW          = 16,
   parameter int unsigned AW          = 6,
   parameter int unsigned LW          = 4,
   parameter bit          CLR_IDLE_RD = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sub_push_i,
   input  logic          sub_pop_i,
   input  logic          reg_push_i,
   input  logic          reg_pop_i,
   input  logic          reg_rd_i,
   input  logic [1:0]    reg_idx_i,
   input  logic          adj_i,
   input  logic [AW-1:0] adj_val_i,
   input  logic          sel_glb_i,
   input  logic          ld_sub_i,
   input  logic          ld_loc_i,
   input  logic          ld_glb_i,
   input  logic [AW-1:0] ld_val_i,
   input  logic [LW-1:0] limit_i,
   input  logic [DW-1:0] wr_data_i,
   output logic [DW-1:0] rd_data_o,
   output logic          rd_valid_o,
   output logic          ovf_o,
   output logic          udf_o,
   output logic [AW-1:0] sub_ptr_o,
   output logic [AW-1:0] loc_ptr_o,
   output logic [AW-1:0] glb_ptr_o
);

   localparam logic [AW-1:0] STEP_UP = AW'(1);
   localparam logic [AW-1:0] STEP_DN = '1;

   if (AW < 3) begin : g_bad_aw
      $error("dual_stack_ram: AW too small for four register offsets");
   end

   stk_op_e             op;
   logic [1:0]          act_ix;
   logic [AW-1:0]       act_ptr;
   logic [N_PTR-1:0]    ld_vec;
   logic [N_PTR-1:0]    step_vec;
   logic [AW-1:0]       delta [N_PTR];
   logic [AW-1:0]       ptr_q [N_PTR];
   logic                any_ld;
   logic                mem_we, mem_re;
   logic [AW-1:0]       waddr, raddr;

   assign ld_vec  = {ld_glb_i, ld_loc_i, ld_sub_i};
   assign any_ld  = |ld_vec;
   assign act_ix  = sel_glb_i ? IX_GLB : IX_LOC;
   assign act_ptr = ptr_q[act_ix];

   // pick one command; loads block all of them, pops beat pushes
   always_comb begin
      op = OP_IDLE;
      if (!any_ld) begin
         if (sub_pop_i)       op = OP_SPOP;
         else if (reg_pop_i)  op = OP_RPOP;
         else if (reg_rd_i)   op = OP_RRD;
         else if (sub_push_i) op = OP_SPUSH;
         else if (reg_push_i) op = OP_RPUSH;
         else if (adj_i)      op = OP_ADJ;
      end
   end

   always_comb begin
      mem_we   = 1'b0;
      mem_re   = 1'b0;
      waddr    = '0;
      raddr    = '0;
      step_vec = '0;
      for (int k = 0; k < N_PTR; k++) delta[k] = '0;
      unique case (op)
         OP_SPOP: begin
            mem_re           = 1'b1;
            raddr            = ptr_q[IX_SUB];
            step_vec[IX_SUB] = 1'b1;
            delta[IX_SUB]    = STEP_DN;
         end
         OP_RPOP: begin
            mem_re           = 1'b1;
            raddr            = act_ptr;
            step_vec[act_ix] = 1'b1;
            delta[act_ix]    = STEP_UP;
         end
         OP_RRD: begin
            mem_re = 1'b1;
            raddr  = act_ptr + AW'(reg_idx_i);
         end
         OP_SPUSH: begin
            mem_we           = 1'b1;
            waddr            = ptr_q[IX_SUB] + STEP_UP;
            step_vec[IX_SUB] = 1'b1;
            delta[IX_SUB]    = STEP_UP;
         end
         OP_RPUSH: begin
            mem_we           = 1'b1;
            waddr            = act_ptr + STEP_DN;
            step_vec[act_ix] = 1'b1;
            delta[act_ix]    = STEP_DN;
         end
         OP_ADJ: begin
            step_vec[act_ix] = 1'b1;
            delta[act_ix]    = adj_val_i;
         end
         default: ;
      endcase
   end

   for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
      dstk_ptr #(.AW(AW), .RST_VAL('0)) u_ptr (
         .clk      (clk),
         .rst_n    (rst_n),
         .ld_i     (ld_vec[g]),
         .ld_val_i (ld_val_i),
         .step_i   (step_vec[g]),
         .delta_i  (delta[g]),
         .q_o      (ptr_q[g])
      );
   end

   dstk_mem #(.DW(DW), .AW(AW), .CLR_IDLE_RD(CLR_IDLE_RD)) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (mem_we),
      .waddr_i  (waddr),
      .wdata_i  (wr_data_i),
      .re_i     (mem_re),
      .raddr_i  (raddr),
      .rdata_o  (rd_data_o),
      .rvalid_o (rd_valid_o)
   );

   dstk_flags #(.AW(AW), .LW(LW)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (mem_we),
      .push_reg_i (op == OP_RPUSH),
      .wr_addr_i  (waddr),
      .pop_i      ((op == OP_SPOP) || (op == OP_RPOP)),
      .rd_addr_i  (raddr),
      .limit_i    (limit_i),
      .ovf_o      (ovf_o),
      .udf_o      (udf_o)
   );

   assign sub_ptr_o = ptr_q[IX_SUB];
   assign loc_ptr_o = ptr_q[IX_LOC];
   assign glb_ptr_o = ptr_q[IX_GLB];

   // R2: subroutine push moves the pointer up by one
   a_r2_spush_inc : assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SPUSH) |=> (sub_ptr_o == $past(sub_ptr_o) + STEP_UP));

   // R3: local register push moves the local pointer down by one
   a_r3_rpush_loc_dec : assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_RPUSH && !sel_glb_i) |=> (loc_ptr_o == $past(loc_ptr_o) + STEP_DN));

   // R4: with the local pointer active, the global pointer is left alone
   a_r4_glb_untouched : assert property (@(posedge clk) disable iff (!rst_n)
      (!any_ld && !sel_glb_i) |=> $stable(glb_ptr_o));

   // R5: register reads leave every pointer where it was
   a_r5_read_keeps_ptrs : assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_RRD) |=> ($stable(sub_ptr_o) && $stable(loc_ptr_o) && $stable(glb_ptr_o)));

   // R10: a subroutine pop wins over a simultaneous subroutine push
   a_r10_pop_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (sub_pop_i && sub_push_i && !any_ld) |=> (sub_ptr_o == $past(sub_ptr_o) + STEP_DN));

endmodule

// File: tb/test_dual_stack_ram.sv
`timescale 1ns/1ps
module test_dual_stack_ram;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sub_push_i, sub_pop_i, reg_push_i, reg_pop_i, reg_rd_i, adj_i;
   logic [1:0]  reg_idx_i;
   logic [5:0]  adj_val_i, ld_val_i;
   logic        sel_glb_i, ld_sub_i, ld_loc_i, ld_glb_i;
   logic [3:0]  limit_i;
   logic [15:0] wr_data_i, rd_data_o;
   logic        rd_valid_o, ovf_o, udf_o;
   logic [5:0]  sub_ptr_o, loc_ptr_o, glb_ptr_o;

   int nchk = 0;
   int nerr = 0;

   logic [5:0]  m_ptr [3];
   logic [15:0] m_mem [64];

   always #2 clk = ~clk;

   dual_stack_ram i_dual_stack_ram (
      .clk(clk), .rst_n(rst_n),
      .sub_push_i(sub_push_i), .sub_pop_i(sub_pop_i),
      .reg_push_i(reg_push_i), .reg_pop_i(reg_pop_i),
      .reg_rd_i(reg_rd_i), .reg_idx_i(reg_idx_i),
      .adj_i(adj_i), .adj_val_i(adj_val_i), .sel_glb_i(sel_glb_i),
      .ld_sub_i(ld_sub_i), .ld_loc_i(ld_loc_i), .ld_glb_i(ld_glb_i),
      .ld_val_i(ld_val_i), .limit_i(limit_i), .wr_data_i(wr_data_i),
      .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
      .ovf_o(ovf_o), .udf_o(udf_o),
      .sub_ptr_o(sub_ptr_o), .loc_ptr_o(loc_ptr_o), .glb_ptr_o(glb_ptr_o)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      sub_push_i = 0; sub_pop_i = 0; reg_push_i = 0; reg_pop_i = 0;
      reg_rd_i = 0; adj_i = 0; reg_idx_i = 0; adj_val_i = 0;
      ld_sub_i = 0; ld_loc_i = 0; ld_glb_i = 0; ld_val_i = 0; wr_data_i = 0;
   endtask

   task automatic chk_ptrs(input string tag);
      chk({tag, " sub ptr"}, 32'(sub_ptr_o), 32'(m_ptr[0]));
      chk({tag, " loc ptr"}, 32'(loc_ptr_o), 32'(m_ptr[1]));
      chk({tag, " glb ptr"}, 32'(glb_ptr_o), 32'(m_ptr[2]));
   endtask

   // one command cycle; expected results follow the priority and
   // pointer ordering rules of R2, R3, R5, R6, R8, R9, R10, R11
   task automatic run(input string tag, input bit sp, input bit so, input bit rp,
                      input bit ro, input bit rr, input bit aj, input logic [1:0] idx,
                      input logic [5:0] av, input logic [15:0] wd);
      int a;
      logic [5:0] ra, wa;
      bit e_val, e_ovf, e_udf;
      logic [15:0] e_dat;
      sub_push_i = sp; sub_pop_i = so; reg_push_i = rp; reg_pop_i = ro;
      reg_rd_i = rr; adj_i = aj; reg_idx_i = idx; adj_val_i = av; wr_data_i = wd;
      a = sel_glb_i ? 2 : 1;
      e_val = 0; e_ovf = 0; e_udf = 0; e_dat = '0; ra = '0;
      if (so) begin
         e_val = 1; ra = m_ptr[0]; m_ptr[0] = m_ptr[0] - 6'd1; e_udf = (ra == 0);
      end else if (ro) begin
         e_val = 1; ra = m_ptr[a]; m_ptr[a] = m_ptr[a] + 6'd1; e_udf = (ra == 0);
      end else if (rr) begin
         e_val = 1; ra = m_ptr[a] + 6'(idx);
      end else if (sp) begin
         wa = m_ptr[0] + 6'd1; m_ptr[0] = wa; m_mem[wa] = wd;
         e_ovf = (wa == {limit_i, 2'b00});
      end else if (rp) begin
         wa = m_ptr[a] - 6'd1; m_ptr[a] = wa; m_mem[wa] = wd;
         e_ovf = (wa == {limit_i, 2'b11});
      end else if (aj) begin
         m_ptr[a] = m_ptr[a] + av;
      end
      if (e_val) e_dat = m_mem[ra];
      @(negedge clk);
      chk({tag, " valid"}, 32'(rd_valid_o), 32'(e_val));
      if (e_val) chk({tag, " data"}, 32'(rd_data_o), 32'(e_dat));
      chk({tag, " ovf"}, 32'(ovf_o), 32'(e_ovf));
      chk({tag, " udf"}, 32'(udf_o), 32'(e_udf));
      chk_ptrs(tag);
      idle_inputs();
   endtask

   // R7: pointer load, optionally together with a subroutine push that must be ignored
   task automatic load(input string tag, input bit ls, input bit ll, input bit lg,
                       input logic [5:0] v, input bit with_push);
      ld_sub_i = ls; ld_loc_i = ll; ld_glb_i = lg; ld_val_i = v;
      sub_push_i = with_push; wr_data_i = 16'hBAD0;
      if (ls) m_ptr[0] = v;
      if (ll) m_ptr[1] = v;
      if (lg) m_ptr[2] = v;
      @(negedge clk);
      chk({tag, " valid"}, 32'(rd_valid_o), 32'd0);
      chk({tag, " ovf"}, 32'(ovf_o), 32'd0);
      chk_ptrs(tag);
      idle_inputs();
   endtask

   task automatic t_reset();
      for (int k = 0; k < 3; k++) m_ptr[k] = '0;
      chk_ptrs("R1 reset");
      chk("R1 reset valid", 32'(rd_valid_o), 32'd0);
      chk("R1 reset ovf", 32'(ovf_o), 32'd0);
      chk("R1 reset udf", 32'(udf_o), 32'd0);
   endtask

   task automatic t_sub_lifo();
      limit_i = 4'd15;
      run("R2 spush a", 1,0,0,0,0,0, 0, 0, 16'h1111);
      run("R2 spush b", 1,0,0,0,0,0, 0, 0, 16'h2222);
      run("R2 spush c", 1,0,0,0,0,0, 0, 0, 16'h3333);
      run("R2 spop c",  0,1,0,0,0,0, 0, 0, 16'h0);
      run("R2 spop b",  0,1,0,0,0,0, 0, 0, 16'h0);
      run("R2 spop a",  0,1,0,0,0,0, 0, 0, 16'h0);
   endtask

   task automatic t_reg_stack();
      load("R7 load loc glb", 0, 1, 1, 6'd40, 0);
      load("R7 load glb", 0, 0, 1, 6'd20, 0);
      sel_glb_i = 0;
      run("R3 R4 rpush loc 0", 0,0,1,0,0,0, 0, 0, 16'hA000);
      run("R3 R4 rpush loc 1", 0,0,1,0,0,0, 0, 0, 16'hA001);
      run("R3 R4 rpush loc 2", 0,0,1,0,0,0, 0, 0, 16'hA002);
      run("R3 R4 rpush loc 3", 0,0,1,0,0,0, 0, 0, 16'hA003);
      sel_glb_i = 1;
      run("R4 rpush glb", 0,0,1,0,0,0, 0, 0, 16'hB000);
      sel_glb_i = 0;
      for (int k = 0; k < 4; k++)
         run("R5 rrd idx", 0,0,0,0,1,0, 2'(k), 0, 16'h0);
      run("R3 rpop loc", 0,0,0,1,0,0, 0, 0, 16'h0);
      run("R6 adj up", 0,0,0,0,0,1, 0, 6'd3, 16'h0);
      run("R6 adj wrap back", 0,0,0,0,0,1, 0, 6'd62, 16'h0);
      run("R5 rrd after adj", 0,0,0,0,1,0, 2'd1, 0, 16'h0);
   endtask

   task automatic t_load_blocks();
      load("R7 load blocks spush", 1, 0, 0, 6'd10, 1);
      run("R7 idle after load", 0,0,0,0,0,0, 0, 0, 16'h0);
   endtask

   task automatic t_overflow();
      limit_i = 4'd2;
      load("R8 load sub", 1, 0, 0, 6'd6, 0);
      run("R8 spush below limit", 1,0,0,0,0,0, 0, 0, 16'h0707);
      run("R8 spush at limit",    1,0,0,0,0,0, 0, 0, 16'h0808);
      run("R8 spush past limit",  1,0,0,0,0,0, 0, 0, 16'h0909);
      sel_glb_i = 1;
      load("R8 load glb", 0, 0, 1, 6'd13, 0);
      run("R8 rpush below limit", 0,0,1,0,0,0, 0, 0, 16'h0C0C);
      run("R8 rpush at limit",    0,0,1,0,0,0, 0, 0, 16'h0B0B);
      run("R8 rpush past limit",  0,0,1,0,0,0, 0, 0, 16'h0A0A);
      sel_glb_i = 0;
      limit_i = 4'd15;
   endtask

   task automatic t_underflow_wrap();
      load("R11 load sub 63", 1, 0, 0, 6'd63, 0);
      run("R11 spush wraps to 0", 1,0,0,0,0,0, 0, 0, 16'h5A5A);
      run("R9 spop at zero", 0,1,0,0,0,0, 0, 0, 16'h0);
      load("R11 load loc 0", 0, 1, 0, 6'd0, 0);
      run("R11 rpush wraps to 63", 0,0,1,0,0,0, 0, 0, 16'h6363);
      run("R9 rpop at 63 no udf", 0,0,0,1,0,0, 0, 0, 16'h0);
      load("R9 load loc 1", 0, 1, 0, 6'd1, 0);
      run("R9 rpush to 0", 0,0,1,0,0,0, 0, 0, 16'hC0DE);
      run("R9 rpop at zero", 0,0,0,1,0,0, 0, 0, 16'h0);
   endtask

   task automatic t_conflict();
      sel_glb_i = 0;
      load("R10 load sub 7", 1, 0, 0, 6'd7, 0);
      run("R10 spush with rpop", 1,0,0,1,0,0, 0, 0, 16'hFFFF);
      load("R10 load loc 8", 0, 1, 0, 6'd8, 0);
      run("R10 word 8 unchanged", 0,0,0,0,1,0, 2'd0, 0, 16'h0);
      run("R10 spush with spop", 1,1,0,0,0,0, 0, 0, 16'hEEEE);
      run("R10 rrd beats spush", 1,0,0,0,1,0, 2'd1, 0, 16'hDDDD);
      run("R10 rpop beats rpush", 0,0,1,1,0,0, 0, 0, 16'hCCCC);
      run("R10 spush beats adj", 1,0,0,0,0,1, 0, 6'd5, 16'h1234);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      idle_inputs();
      sel_glb_i = 0;
      limit_i = 4'd15;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_sub_lifo();
      t_reg_stack();
      t_load_blocks();
      t_overflow();
      t_underflow_wrap();
      t_conflict();
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule